// File: doc/BRIEF.md
# Accumulator Multiply-Divide Unit

This unit performs integer multiplication and division over a fixed register mapping. Each request brings the accumulator pair (AX and DX), a source operand and three control bits: operation, signedness and operand width. It returns new AX and DX values and a divide-error flag. A byte multiply places its 16-bit product in AX. A word multiply places its 32-bit product across DX (upper half) and AX (lower half). A byte divide takes AX as the dividend and returns the quotient in the low byte of AX and the remainder in the high byte. A word divide takes DX:AX as the dividend and returns the quotient in AX and the remainder in DX.

Internally the unit is iterative. There is one setup cycle, then one shift-add or restoring-subtract step per operand bit, then one cycle that writes the result. The request side is a valid/ready pair. `req_ready` is high only while the unit is idle, and a request transfers on a clock edge where both `req_valid` and `req_ready` are high. Holding `req_valid` while `req_ready` is low is the back-pressure case: the request simply waits. The response side is a single-cycle `rsp_valid` pulse with no ready input. A consumer must take the result in that cycle, but the output registers keep their values until the next response.

Top module: `acc_muldiv`

## Requirements
- R1: `req_ready` equals the negation of `busy`. A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. `busy` is 1 from the cycle after acceptance until the cycle in which `rsp_valid` is 1, and in that cycle `busy` is 0. `rsp_valid` is high for exactly one cycle per request. After reset, `busy`, `rsp_valid`, `div_err`, `ax_out` and `dx_out` are all 0 and `req_ready` is 1.
- R2: `rsp_valid` rises N+2 clock edges after the accepting edge, where N is the operand width in bits: 10 edges for byte operations (`op_word`=0) and 18 edges for word operations (`op_word`=1).
- R3: A byte multiply (`op_div`=0, `op_word`=0) sets `ax_out` to the 16-bit product of `ax_in[7:0]` and `src_in[7:0]`. `ax_in[15:8]` is ignored, and `dx_out` is set equal to `dx_in`.
- R4: A word multiply sets {`dx_out`,`ax_out`} to the 32-bit product of `ax_in` and `src_in`.
- R5: A byte divide (`op_div`=1, `op_word`=0) divides `ax_in` by `src_in[7:0]`. It places the quotient in `ax_out[7:0]` and the remainder in `ax_out[15:8]`, and sets `dx_out` equal to `dx_in`.
- R6: A word divide divides {`dx_in`,`ax_in`} by `src_in`. It places the quotient in `ax_out` and the remainder in `dx_out`.
- R7: With `op_signed`=1, operands are read as two's complement numbers and the register mapping stays the same. The product is signed. The quotient truncates toward zero, and the remainder takes the sign of the dividend.
- R8: A divide by zero sets `div_err` to 1 and sets `ax_out` and `dx_out` equal to the latched `ax_in` and `dx_in`.
- R9: A divide whose quotient does not fit the destination sets `div_err` and leaves AX/DX unchanged, as in R8. For an N-bit unsigned divide the quotient must lie in 0..2^N-1. For a signed divide it must lie in -2^(N-1)..2^(N-1)-1, and a quotient of exactly -2^(N-1) is valid.
- R10: A multiply never sets `div_err`. `ax_out`, `dx_out` and `div_err` change only in a cycle in which `rsp_valid` is 1.
- R11: Operand and control inputs are sampled only on the accepting edge. Changing them while `busy` is 1 has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| op_div | input | 1 | 1 = divide, 0 = multiply |
| op_signed | input | 1 | 1 = two's complement operands |
| op_word | input | 1 | 1 = 16-bit operation, 0 = 8-bit operation |
| ax_in | input | 16 | Accumulator low register value |
| dx_in | input | 16 | Accumulator high register value |
| src_in | input | 16 | Source operand (low byte used in byte mode) |
| busy | output | 1 | Operation in progress |
| rsp_valid | output | 1 | One-cycle result strobe |
| ax_out | output | 16 | New AX value |
| dx_out | output | 16 | New DX value |
| div_err | output | 1 | Divide error (zero divisor or quotient overflow) |

## Verification
Multiplies are run with all-ones operands, where the carry into the top product bit must propagate, and with a nonzero high byte in AX, which shows whether byte mode really ignores it. Divides use dividends whose high part is just below the divisor, which exercises the last restoring step, and dividends whose high part equals the divisor, which separates a legal quotient from an overflow. Signed cases mix the four sign combinations, so that truncation toward zero and the sign of the remainder are told apart from floor division. The boundary quotient -2^(N-1) is paired with +2^(N-1) to separate the asymmetric signed range. Inputs are scrambled while the unit is busy, which shows that sampling happens only on the accepting edge.

// File: rtl/acc_muldiv_pkg.sv
package acc_muldiv_pkg;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SETUP,
    S_ITER,
    S_FIN
  } mdu_state_e;

  typedef struct packed {
    logic is_div;
    logic is_signed;
    logic is_word;
  } mdu_cmd_t;

endpackage

// File: rtl/acc_muldiv_prep.sv
// Converts latched operands into unsigned magnitudes plus result signs.
module acc_muldiv_prep
  import acc_muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  mdu_cmd_t       cmd,
  input  logic [W-1:0]   ax,
  input  logic [W-1:0]   dx,
  input  logic [W-1:0]   src,
  output logic [W-1:0]   a_mag,
  output logic [W-1:0]   b_mag,
  output logic [2*W-1:0] dvd_mag,
  output logic           neg_q,
  output logic           neg_r
);
  localparam int H = W / 2;

  logic           sa, sb, sd;
  logic [H-1:0]   ax_lo_neg, src_lo_neg;
  logic [W-1:0]   ax_neg, src_neg;
  logic [2*W-1:0] pair_neg;

  always_comb begin
    ax_lo_neg  = -ax[H-1:0];
    src_lo_neg = -src[H-1:0];
    ax_neg     = -ax;
    src_neg    = -src;
    pair_neg   = -{dx, ax};

    sa = cmd.is_signed & (cmd.is_word ? ax[W-1]  : ax[H-1]);
    sb = cmd.is_signed & (cmd.is_word ? src[W-1] : src[H-1]);
    sd = cmd.is_signed & (cmd.is_word ? dx[W-1]  : ax[W-1]);

    if (cmd.is_word) a_mag = sa ? ax_neg : ax;
    else             a_mag = {{H{1'b0}}, (sa ? ax_lo_neg : ax[H-1:0])};

    if (cmd.is_word) b_mag = sb ? src_neg : src;
    else             b_mag = {{H{1'b0}}, (sb ? src_lo_neg : src[H-1:0])};

    if (cmd.is_word) dvd_mag = sd ? pair_neg : {dx, ax};
    else             dvd_mag = {{W{1'b0}}, (sd ? ax_neg : ax)};

    neg_q = cmd.is_div ? (sd ^ sb) : (sa ^ sb);
    neg_r = sd;
  end
endmodule

// File: rtl/acc_muldiv_core.sv
// One bit per cycle: shift-add multiply or restoring divide on magnitudes.
module acc_muldiv_core #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           is_div,
  input  logic           is_word,
  input  logic [W-1:0]   a_mag,
  input  logic [W-1:0]   b_mag,
  input  logic [2*W-1:0] dvd_mag,
  output logic [2*W-1:0] prod_mag,
  output logic [W-1:0]   quo_mag,
  output logic [W-1:0]   rem_mag,
  output logic           ovf_pre
);
  localparam int H = W / 2;

  logic [W:0]   hi;
  logic [W-1:0] lo;
  logic         ovf_q;

  logic [W:0]   mul_sum;
  logic         lo_top;
  logic [W:0]   div_shift;
  logic [W+1:0] div_trial;
  logic         div_ge;
  logic [W-1:0] dvd_hi, dvd_lo;

  always_comb begin
    mul_sum   = hi + (lo[0] ? {1'b0, a_mag} : '0);
    lo_top    = is_word ? lo[W-1] : lo[H-1];
    div_shift = {hi[W-1:0], lo_top};
    div_trial = {1'b0, div_shift} - {2'b00, b_mag};
    div_ge    = ~div_trial[W+1];
    dvd_hi    = is_word ? dvd_mag[2*W-1:W] : {{H{1'b0}}, dvd_mag[W-1:H]};
    dvd_lo    = is_word ? dvd_mag[W-1:0]   : {{H{1'b0}}, dvd_mag[H-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi    <= '0;
      lo    <= '0;
      ovf_q <= 1'b0;
    end else if (load) begin
      if (is_div) begin
        hi    <= {1'b0, dvd_hi};
        lo    <= dvd_lo;
        ovf_q <= (dvd_hi >= b_mag);
      end else begin
        hi    <= '0;
        lo    <= b_mag;
        ovf_q <= 1'b0;
      end
    end else if (step) begin
      if (is_div) begin
        hi <= div_ge ? div_trial[W:0] : div_shift;
        lo <= {lo[W-2:0], div_ge};
      end else begin
        {hi, lo} <= {mul_sum, lo} >> 1;
      end
    end
  end

  assign prod_mag = is_word ? {hi[W-1:0], lo} : {{W{1'b0}}, hi[H-1:0], lo[W-1:H]};
  assign quo_mag  = is_word ? lo : {{H{1'b0}}, lo[H-1:0]};
  assign rem_mag  = hi[W-1:0];
  assign ovf_pre  = ovf_q;
endmodule

// File: rtl/acc_muldiv_pack.sv
// Applies signs, checks the quotient range and places results in AX/DX.
module acc_muldiv_pack
  import acc_muldiv_pkg::*;
#(
  parameter int W = 16
) (
  input  mdu_cmd_t       cmd,
  input  logic           neg_q,
  input  logic           neg_r,
  input  logic [2*W-1:0] prod_mag,
  input  logic [W-1:0]   quo_mag,
  input  logic [W-1:0]   rem_mag,
  input  logic           ovf_pre,
  input  logic [W-1:0]   ax_in,
  input  logic [W-1:0]   dx_in,
  output logic [W-1:0]   ax_new,
  output logic [W-1:0]   dx_new,
  output logic           err
);
  localparam int H = W / 2;

  logic [2*W-1:0] prod_s;
  logic [W-1:0]   quo_s, rem_s;
  logic           q_top, q_rest_nz, range_bad;

  always_comb begin
    prod_s    = neg_q ? -prod_mag : prod_mag;
    quo_s     = neg_q ? -quo_mag  : quo_mag;
    rem_s     = neg_r ? -rem_mag  : rem_mag;
    q_top     = cmd.is_word ? quo_mag[W-1] : quo_mag[H-1];
    q_rest_nz = cmd.is_word ? (|quo_mag[W-2:0]) : (|quo_mag[H-2:0]);
    range_bad = cmd.is_signed & q_top & (~neg_q | q_rest_nz);
    err       = cmd.is_div & (ovf_pre | range_bad);

    ax_new = ax_in;
    dx_new = dx_in;
    if (!err) begin
      if (cmd.is_div) begin
        if (cmd.is_word) begin
          ax_new = quo_s;
          dx_new = rem_s;
        end else begin
          ax_new = {rem_s[H-1:0], quo_s[H-1:0]};
        end
      end else begin
        ax_new = prod_s[W-1:0];
        if (cmd.is_word) dx_new = prod_s[2*W-1:W];
      end
    end
  end
endmodule

// File: rtl/acc_muldiv.sv
module acc_muldiv
  import acc_muldiv_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              op_div,
  input  logic              op_signed,
  input  logic              op_word,
  input  logic [DATA_W-1:0] ax_in,
  input  logic [DATA_W-1:0] dx_in,
  input  logic [DATA_W-1:0] src_in,
  output logic              busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] ax_out,
  output logic [DATA_W-1:0] dx_out,
  output logic              div_err
);
  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W + 1);

  mdu_state_e        state;
  mdu_cmd_t          cmd_q;
  logic [DATA_W-1:0] ax_q, dx_q, src_q;
  logic [CNT_W-1:0]  step_cnt;
  logic              accept;

  logic [DATA_W-1:0]   a_mag, b_mag, quo_mag, rem_mag, ax_new, dx_new;
  logic [2*DATA_W-1:0] dvd_mag, prod_mag;
  logic                neg_q, neg_r, ovf_pre, err_new;

  assign busy      = (state != S_IDLE);
  assign req_ready = ~busy;
  assign accept    = req_valid & req_ready;

  acc_muldiv_prep #(.W(DATA_W)) u_prep (
    .cmd     (cmd_q),
    .ax      (ax_q),
    .dx      (dx_q),
    .src     (src_q),
    .a_mag   (a_mag),
    .b_mag   (b_mag),
    .dvd_mag (dvd_mag),
    .neg_q   (neg_q),
    .neg_r   (neg_r)
  );

  acc_muldiv_core #(.W(DATA_W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (state == S_SETUP),
    .step     (state == S_ITER),
    .is_div   (cmd_q.is_div),
    .is_word  (cmd_q.is_word),
    .a_mag    (a_mag),
    .b_mag    (b_mag),
    .dvd_mag  (dvd_mag),
    .prod_mag (prod_mag),
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .ovf_pre  (ovf_pre)
  );

  acc_muldiv_pack #(.W(DATA_W)) u_pack (
    .cmd      (cmd_q),
    .neg_q    (neg_q),
    .neg_r    (neg_r),
    .prod_mag (prod_mag),
    .quo_mag  (quo_mag),
    .rem_mag  (rem_mag),
    .ovf_pre  (ovf_pre),
    .ax_in    (ax_q),
    .dx_in    (dx_q),
    .ax_new   (ax_new),
    .dx_new   (dx_new),
    .err      (err_new)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd_q     <= '0;
      ax_q      <= '0;
      dx_q      <= '0;
      src_q     <= '0;
      step_cnt  <= '0;
      ax_out    <= '0;
      dx_out    <= '0;
      div_err   <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          cmd_q <= '{is_div: op_div, is_signed: op_signed, is_word: op_word};
          ax_q  <= ax_in;
          dx_q  <= dx_in;
          src_q <= src_in;
          state <= S_SETUP;
        end
        S_SETUP: begin
          step_cnt <= cmd_q.is_word ? CNT_W'(DATA_W) : CNT_W'(HALF_W);
          state    <= S_ITER;
        end
        S_ITER: begin
          step_cnt <= step_cnt - 1'b1;
          if (step_cnt == CNT_W'(1)) state <= S_FIN;
        end
        S_FIN: begin
          ax_out    <= ax_new;
          dx_out    <= dx_new;
          div_err   <= err_new;
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/acc_muldiv_chk.sv
module acc_muldiv_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              op_div,
  input logic              op_word,
  input logic [DATA_W-1:0] ax_in,
  input logic [DATA_W-1:0] dx_in,
  input logic              busy,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] ax_out,
  input logic [DATA_W-1:0] dx_out,
  input logic              div_err
);
  localparam int LAT_W = $clog2(DATA_W + 3) + 1;
  localparam int LAT_B = DATA_W / 2 + 2;
  localparam int LAT_H = DATA_W + 2;

  logic              cap_div, cap_word;
  logic [DATA_W-1:0] cap_ax, cap_dx;
  logic [LAT_W-1:0]  lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_div  <= 1'b0;
      cap_word <= 1'b0;
      cap_ax   <= '0;
      cap_dx   <= '0;
      lat_cnt  <= '0;
    end else if (req_valid && req_ready) begin
      cap_div  <= op_div;
      cap_word <= op_word;
      cap_ax   <= ax_in;
      cap_dx   <= dx_in;
      lat_cnt  <= '0;
    end else if (busy) begin
      lat_cnt  <= lat_cnt + 1'b1;
    end
  end

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_busy_ends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rsp_valid);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (lat_cnt == (cap_word ? LAT_W'(LAT_H) : LAT_W'(LAT_B))));

  p_byte_keeps_dx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cap_word) |-> (dx_out == cap_dx));

  p_err_unchanged_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && div_err) |-> (ax_out == cap_ax && dx_out == cap_dx));

  p_mul_no_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cap_div) |-> !div_err);

  p_outputs_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> $stable({ax_out, dx_out, div_err}));
endmodule

bind acc_muldiv acc_muldiv_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .op_div    (op_div),
  .op_word   (op_word),
  .ax_in     (ax_in),
  .dx_in     (dx_in),
  .busy      (busy),
  .rsp_valid (rsp_valid),
  .ax_out    (ax_out),
  .dx_out    (dx_out),
  .div_err   (div_err)
);

// File: tb/acc_muldiv_test.sv
module acc_muldiv_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        op_div = 1'b0, op_signed = 1'b0, op_word = 1'b0;
  logic [15:0] ax_in = '0, dx_in = '0, src_in = '0;
  logic        req_ready, busy, rsp_valid, div_err;
  logic [15:0] ax_out, dx_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  acc_muldiv uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .op_div(op_div), .op_signed(op_signed), .op_word(op_word),
    .ax_in(ax_in), .dx_in(dx_in), .src_in(src_in),
    .busy(busy), .rsp_valid(rsp_valid), .ax_out(ax_out), .dx_out(dx_out),
    .div_err(div_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Independent arithmetic model of the requirements.
  function automatic void ref_model(input bit dv, input bit sg, input bit wd,
                                    input logic [15:0] ax, input logic [15:0] dx,
                                    input logic [15:0] src,
                                    output logic [15:0] eax, output logic [15:0] edx,
                                    output bit eerr);
    longint a, b, p, dvd, dvs, q, r, n;
    n = wd ? 16 : 8;
    eax = ax; edx = dx; eerr = 1'b0;
    if (!dv) begin
      if (sg) begin
        a = wd ? longint'($signed(ax))  : longint'($signed(ax[7:0]));
        b = wd ? longint'($signed(src)) : longint'($signed(src[7:0]));
      end else begin
        a = wd ? longint'(ax)  : longint'(ax[7:0]);
        b = wd ? longint'(src) : longint'(src[7:0]);
      end
      p = a * b;
      if (wd) begin
        eax = p[15:0];
        edx = p[31:16];
      end else begin
        eax = p[15:0];
      end
    end else begin
      if (sg) begin
        dvd = wd ? longint'($signed({dx, ax})) : longint'($signed(ax));
        dvs = wd ? longint'($signed(src)) : longint'($signed(src[7:0]));
      end else begin
        dvd = wd ? longint'({dx, ax}) : longint'(ax);
        dvs = wd ? longint'(src) : longint'(src[7:0]);
      end
      if (dvs == 0) begin
        eerr = 1'b1;
      end else begin
        q = dvd / dvs;
        r = dvd % dvs;
        if (sg) eerr = (q > (64'sd1 << (n - 1)) - 1) || (q < -(64'sd1 << (n - 1)));
        else    eerr = (q > (64'sd1 << n) - 1);
        if (!eerr) begin
          if (wd) begin
            eax = q[15:0];
            edx = r[15:0];
          end else begin
            eax = {r[7:0], q[7:0]};
          end
        end
      end
    end
  endfunction

  // Issues one request, scrambles inputs while busy, checks all results.
  task automatic run_op(input bit dv, input bit sg, input bit wd,
                        input logic [15:0] ax, input logic [15:0] dx,
                        input logic [15:0] src, input string rq);
    logic [15:0] eax, edx;
    bit eerr;
    int cycles;
    bit busy_ok;
    ref_model(dv, sg, wd, ax, dx, src, eax, edx, eerr);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; op_div = dv; op_signed = sg; op_word = wd;
    ax_in = ax; dx_in = dx; src_in = src;
    @(negedge clk);
    // R11: scramble everything after the accepting edge
    req_valid = 1'b0; op_div = ~dv; op_signed = ~sg; op_word = ~wd;
    ax_in = ~ax; dx_in = ~dx; src_in = src ^ 16'h5A5A;
    cycles = 0;
    busy_ok = 1'b1;
    while (!rsp_valid && cycles < 60) begin
      if (!busy || req_ready) busy_ok = 1'b0;
      @(negedge clk);
      cycles++;
    end
    check(busy_ok, "R1", "busy/ready while working", busy_ok, 1);
    check(rsp_valid && !busy, "R1", "rsp_valid with busy low", {rsp_valid, busy}, 2'b10);
    check(cycles == (wd ? 18 : 10), "R2", "latency edges", cycles, wd ? 18 : 10);
    check(ax_out == eax, rq, "ax_out", ax_out, eax);
    check(dx_out == edx, rq, "dx_out", dx_out, edx);
    check(div_err == eerr, rq, "div_err", div_err, eerr);
    @(negedge clk);
    check(!rsp_valid, "R1", "rsp_valid single cycle", rsp_valid, 0);
    check(ax_out == eax && dx_out == edx && div_err == eerr, "R10", "outputs hold",
          {ax_out, dx_out}, {eax, edx});
  endtask

  task automatic test_reset();
    check(req_ready && !busy && !rsp_valid, "R1", "reset handshake",
          {req_ready, busy, rsp_valid}, 3'b100);
    check(ax_out == 0 && dx_out == 0 && !div_err, "R1", "reset outputs",
          {ax_out, dx_out, div_err}, 0);
  endtask

  task automatic test_byte_mul();
    run_op(0, 0, 0, 16'h12FF, 16'hBEEF, 16'h77FF, "R3");  // high AX byte ignored
    run_op(0, 0, 0, 16'h0007, 16'h1234, 16'h0009, "R3");
    run_op(0, 0, 0, 16'h0000, 16'hFFFF, 16'h00AB, "R3");
  endtask

  task automatic test_word_mul();
    run_op(0, 0, 1, 16'hFFFF, 16'h1111, 16'hFFFF, "R4");
    run_op(0, 0, 1, 16'h1234, 16'h0000, 16'h5678, "R4");
  endtask

  task automatic test_byte_div();
    run_op(1, 0, 0, 16'h0403, 16'hCAFE, 16'h0010, "R5");
    run_op(1, 0, 0, 16'hFEFF, 16'h0001, 16'h00FF, "R5");  // quotient 255, top legal
  endtask

  task automatic test_word_div();
    run_op(1, 0, 1, 16'h0000, 16'h0001, 16'h0003, "R6");
    run_op(1, 0, 1, 16'hFFFF, 16'hFFFE, 16'hFFFF, "R6");  // quotient 0xFFFF
  endtask

  task automatic test_signed();
    run_op(0, 1, 0, 16'h00FE, 16'h0000, 16'h0003, "R7");  // -2 * 3
    run_op(0, 1, 1, 16'hFFFF, 16'h0000, 16'hFFFF, "R7");  // -1 * -1
    run_op(0, 1, 1, 16'h8000, 16'h0000, 16'h7FFF, "R7");
    run_op(1, 1, 0, 16'hFFF9, 16'h0000, 16'h0002, "R7");  // -7 / 2
    run_op(1, 1, 1, 16'h0007, 16'h0000, 16'hFFFE, "R7");  // 7 / -2
    run_op(1, 1, 1, 16'hFFF9, 16'hFFFF, 16'hFFFE, "R7");  // -7 / -2
  endtask

  task automatic test_div_zero();
    run_op(1, 0, 0, 16'h1234, 16'h5678, 16'hFF00, "R8");  // low byte zero
    run_op(1, 1, 1, 16'hABCD, 16'h0042, 16'h0000, "R8");
  endtask

  task automatic test_overflow();
    run_op(1, 0, 0, 16'h1000, 16'h0000, 16'h0010, "R9");  // 256
    run_op(1, 1, 0, 16'hFF80, 16'h0000, 16'h0001, "R9");  // -128 legal
    run_op(1, 1, 0, 16'h0080, 16'h0000, 16'h0001, "R9");  // +128 overflow
    run_op(1, 1, 1, 16'h8000, 16'hFFFF, 16'h0001, "R9");  // -32768 legal
    run_op(1, 1, 1, 16'h8000, 16'h0000, 16'h0001, "R9");  // +32768 overflow
    run_op(1, 0, 1, 16'h0000, 16'h0005, 16'h0005, "R9");
  endtask

  task automatic test_latch();
    run_op(0, 0, 1, 16'h00FF, 16'h0000, 16'h0101, "R11");
    run_op(1, 0, 0, 16'h0064, 16'h0000, 16'h0007, "R11");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_byte_mul();
    test_word_mul();
    test_byte_div();
    test_word_div();
    test_signed();
    test_div_zero();
    test_overflow();
    test_latch();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule